// File: doc/BRIEF.md
# Default-Backup Bypass Datapath

This block is the fault bypass that sits beside the crossbar of one mesh router. It drives the router's X+ link and a core ejection port. In normal operation the X+ link simply carries whatever the crossbar sends to it. When any monitored module of the router is marked broken, the block enters bypass mode. In that mode the X+ link is fed instead by a three-way selector. The selector takes flits straight from the X- input, which is the upstream segment of a one-way ring threaded through every router. It also takes flits from the local core's injection stream. The crossbar is not involved, so the local core stays reachable whether the broken part is the crossbar, an input queue or the network interface.

Packets are wormhole-switched and move under valid/ready flow control. Once a packet wins the X+ link, it keeps the link until its tail flit has gone. A packet arriving on the ring whose head names this node leaves through the ejection port instead of the ring. That ejection can run in the same cycles as a local injection onto X+. Locally injected packets join the ring on the higher of the two virtual channels.

Top module: `dbp_bypass_top`

Flit layout used throughout (64 bits): bit 63 marks a head flit, bit 62 marks a tail flit (a one-flit packet has both set), bit 61 is the virtual channel, bits 60..57 are the destination node, and the remaining low bits are payload.

The X+ owner machine has four states:
- IDLE: no packet holds the link.
- XBAR_LOCK: a crossbar packet holds the link.
- RING_LOCK: a forwarded ring packet holds the link.
- INJ_LOCK: an injected packet holds the link.

It moves from IDLE to a lock state when a non-tail head is accepted. It moves from any lock state back to IDLE when that packet's tail is accepted. A one-flit packet leaves it in IDLE.

The ring-steer machine has two states:
- SCAN: looks at arriving ring heads.
- EJECTING: takes a packet that is addressed here.

It moves from SCAN to EJECTING when a non-tail head addressed to this node is accepted. It moves back to SCAN on that packet's tail.

## Requirements
- R1: In normal mode, a crossbar packet is passed to X+ unchanged and the crossbar sees the X+ ready. Ring and injection ready stay low and the ejection port shows no valid flit.
- R2: In bypass mode, the crossbar ready stays low whenever no crossbar packet is in progress. X+ is then fed only from the ring or from injection.
- R3: In bypass mode, a ring head (bit 63 set) whose destination field (bits 60..57) differs from the node ID is forwarded to X+ unchanged, together with the rest of its packet.
- R4: In bypass mode, a ring head whose destination equals the node ID is delivered to the ejection port, and so is the rest of its packet up to its tail (bit 62).
- R5: Every injected flit leaves on X+ with its virtual-channel bit (bit 61) set to 1. All other bits are unchanged. Ring and crossbar flits keep their channel bit.
- R6: After a non-tail head is accepted on X+, X+ carries only flits of that packet until its tail is accepted. No other head appears in between.
- R7: When, at a packet boundary in bypass mode, a ring packet for X+ and an injected head are both waiting, the ring packet is granted first.
- R8: A packet being ejected and a packet being injected onto X+ can both move in the same cycle.
- R9: The fault vector is taken in only when neither machine holds a packet. A change that arrives mid-packet takes effect after the tail.
- R10: Reset puts both machines in their idle states and selects normal mode. In the first cycle after reset, a crossbar head is passed even if fault bits are already set.
- R11: An output is valid only when its selected source is valid, and each source's ready equals the ready of the output it is routed to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id_i | input | NODE_W | Address of this node |
| fault_i | input | FAULT_W | One bit per monitored module, 1 = broken |
| xbar_valid_i | input | 1 | Crossbar X+ flit valid |
| xbar_flit_i | input | FLIT_W | Crossbar X+ flit |
| xbar_ready_o | output | 1 | Crossbar flit accepted |
| ring_valid_i | input | 1 | X- ring flit valid |
| ring_flit_i | input | FLIT_W | X- ring flit |
| ring_ready_o | output | 1 | Ring flit accepted |
| inj_valid_i | input | 1 | Local injection flit valid |
| inj_flit_i | input | FLIT_W | Local injection flit |
| inj_ready_o | output | 1 | Injection flit accepted |
| xplus_valid_o | output | 1 | X+ link flit valid |
| xplus_flit_o | output | FLIT_W | X+ link flit |
| xplus_ready_i | input | 1 | X+ link can take a flit |
| eject_valid_o | output | 1 | Ejection flit valid |
| eject_flit_o | output | FLIT_W | Ejection flit |
| eject_ready_i | input | 1 | Core can take an ejected flit |

## Verification
Two functions can fall in the same cycle. The first is a ring packet addressed to this node being ejected. The second is a local packet being injected onto X+. A third case is a forwarding ring head and an injected head arriving together at an idle link. Both situations are provoked by loading the ring and injection streams at once while the X+ and ejection readies follow different stall patterns. A behavioural model in the bench predicts, cycle by cycle, which source owns X+, whether ejection is active, and every ready and valid. The DUT is compared against it every cycle. Fault bits are also changed in the middle of a crossbar packet, to show that the mode switch waits for the tail.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

    localparam int FLIT_W_DEF  = 64;
    localparam int NODE_W_DEF  = 4;
    localparam int FAULT_W_DEF = 3;

    typedef enum logic [1:0] {
        OS_IDLE,
        OS_XBAR,
        OS_RING,
        OS_INJ
    } out_state_e;

    typedef enum logic {
        RS_SCAN,
        RS_EJECT
    } steer_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_XBAR,
        SRC_RING,
        SRC_INJ
    } src_sel_e;

endpackage

// File: rtl/dbp_mode_latch.sv
module dbp_mode_latch #(
    parameter int FAULT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FAULT_W-1:0] fault_i,
    input  logic               boundary_i,
    output logic               bypass_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bypass_o <= 1'b0;
        end else if (boundary_i) begin
            bypass_o <= |fault_i;
        end
    end

endmodule

// File: rtl/dbp_ring_steer.sv
module dbp_ring_steer
    import dbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bypass_i,
    input  logic ring_valid_i,
    input  logic ring_head_i,
    input  logic ring_tail_i,
    input  logic dest_match_i,
    input  logic eject_ready_i,
    output logic eject_valid_o,
    output logic fwd_req_o,
    output logic idle_o
);

    steer_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_SCAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d       = state_q;
        eject_valid_o = 1'b0;
        fwd_req_o     = 1'b0;
        unique case (state_q)
            RS_SCAN: begin
                if (bypass_i && ring_valid_i && ring_head_i) begin
                    if (dest_match_i) begin
                        eject_valid_o = 1'b1;
                        if (eject_ready_i && !ring_tail_i) begin
                            state_d = RS_EJECT;
                        end
                    end else begin
                        fwd_req_o = 1'b1;
                    end
                end
            end
            RS_EJECT: begin
                eject_valid_o = ring_valid_i;
                if (ring_valid_i && eject_ready_i && ring_tail_i) begin
                    state_d = RS_SCAN;
                end
            end
            default: state_d = RS_SCAN;
        endcase
    end

    assign idle_o = (state_q == RS_SCAN);

endmodule

// File: rtl/dbp_xplus_arb.sv
module dbp_xplus_arb
    import dbp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bypass_i,
    input  logic     xbar_valid_i,
    input  logic     xbar_head_i,
    input  logic     xbar_tail_i,
    input  logic     ring_fwd_req_i,
    input  logic     ring_valid_i,
    input  logic     ring_tail_i,
    input  logic     inj_valid_i,
    input  logic     inj_head_i,
    input  logic     inj_tail_i,
    input  logic     xplus_ready_i,
    output src_sel_e sel_o,
    output logic     idle_o
);

    out_state_e state_q, state_d;
    logic       src_valid;
    logic       src_tail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        sel_o     = SRC_NONE;
        src_valid = 1'b0;
        src_tail  = 1'b0;

        unique case (state_q)
            OS_IDLE: begin
                if (!bypass_i) begin
                    if (xbar_valid_i && xbar_head_i) sel_o = SRC_XBAR;
                end else if (ring_fwd_req_i) begin
                    sel_o = SRC_RING;
                end else if (inj_valid_i && inj_head_i) begin
                    sel_o = SRC_INJ;
                end
            end
            OS_XBAR: sel_o = SRC_XBAR;
            OS_RING: sel_o = SRC_RING;
            OS_INJ:  sel_o = SRC_INJ;
            default: sel_o = SRC_NONE;
        endcase

        unique case (sel_o)
            SRC_XBAR: begin src_valid = xbar_valid_i; src_tail = xbar_tail_i; end
            SRC_RING: begin src_valid = ring_valid_i; src_tail = ring_tail_i; end
            SRC_INJ:  begin src_valid = inj_valid_i;  src_tail = inj_tail_i;  end
            default:  begin src_valid = 1'b0;         src_tail = 1'b0;        end
        endcase

        if (src_valid && xplus_ready_i) begin
            if (state_q == OS_IDLE) begin
                if (!src_tail) begin
                    unique case (sel_o)
                        SRC_XBAR: state_d = OS_XBAR;
                        SRC_RING: state_d = OS_RING;
                        SRC_INJ:  state_d = OS_INJ;
                        default:  state_d = OS_IDLE;
                    endcase
                end
            end else if (src_tail) begin
                state_d = OS_IDLE;
            end
        end
    end

    assign idle_o = (state_q == OS_IDLE);

endmodule

// File: rtl/dbp_bypass_top.sv
module dbp_bypass_top
    import dbp_pkg::*;
#(
    parameter int FLIT_W     = FLIT_W_DEF,
    parameter int NODE_W     = NODE_W_DEF,
    parameter int FAULT_W    = FAULT_W_DEF,
    parameter bit PROMOTE_VC = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NODE_W-1:0]  node_id_i,
    input  logic [FAULT_W-1:0] fault_i,
    input  logic               xbar_valid_i,
    input  logic [FLIT_W-1:0]  xbar_flit_i,
    output logic               xbar_ready_o,
    input  logic               ring_valid_i,
    input  logic [FLIT_W-1:0]  ring_flit_i,
    output logic               ring_ready_o,
    input  logic               inj_valid_i,
    input  logic [FLIT_W-1:0]  inj_flit_i,
    output logic               inj_ready_o,
    output logic               xplus_valid_o,
    output logic [FLIT_W-1:0]  xplus_flit_o,
    input  logic               xplus_ready_i,
    output logic               eject_valid_o,
    output logic [FLIT_W-1:0]  eject_flit_o,
    input  logic               eject_ready_i
);

    localparam int HEAD_BIT = FLIT_W - 1;
    localparam int TAIL_BIT = FLIT_W - 2;
    localparam int VC_BIT   = FLIT_W - 3;
    localparam int DEST_MSB = FLIT_W - 4;
    localparam int DEST_LSB = DEST_MSB - NODE_W + 1;

    logic        bypass_q;
    logic        arb_idle;
    logic        steer_idle;
    logic        ring_fwd_req;
    logic        dest_match;
    src_sel_e    sel;
    logic [FLIT_W-1:0] inj_out;

    assign dest_match = (ring_flit_i[DEST_MSB:DEST_LSB] == node_id_i);

    dbp_mode_latch #(.FAULT_W(FAULT_W)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_i    (fault_i),
        .boundary_i (arb_idle && steer_idle),
        .bypass_o   (bypass_q)
    );

    dbp_ring_steer u_steer (
        .clk           (clk),
        .rst_n         (rst_n),
        .bypass_i      (bypass_q),
        .ring_valid_i  (ring_valid_i),
        .ring_head_i   (ring_flit_i[HEAD_BIT]),
        .ring_tail_i   (ring_flit_i[TAIL_BIT]),
        .dest_match_i  (dest_match),
        .eject_ready_i (eject_ready_i),
        .eject_valid_o (eject_valid_o),
        .fwd_req_o     (ring_fwd_req),
        .idle_o        (steer_idle)
    );

    dbp_xplus_arb u_arb (
        .clk            (clk),
        .rst_n          (rst_n),
        .bypass_i       (bypass_q),
        .xbar_valid_i   (xbar_valid_i),
        .xbar_head_i    (xbar_flit_i[HEAD_BIT]),
        .xbar_tail_i    (xbar_flit_i[TAIL_BIT]),
        .ring_fwd_req_i (ring_fwd_req),
        .ring_valid_i   (ring_valid_i),
        .ring_tail_i    (ring_flit_i[TAIL_BIT]),
        .inj_valid_i    (inj_valid_i),
        .inj_head_i     (inj_flit_i[HEAD_BIT]),
        .inj_tail_i     (inj_flit_i[TAIL_BIT]),
        .xplus_ready_i  (xplus_ready_i),
        .sel_o          (sel),
        .idle_o         (arb_idle)
    );

    generate
        if (PROMOTE_VC) begin : g_promote
            always_comb begin
                inj_out         = inj_flit_i;
                inj_out[VC_BIT] = 1'b1;
            end
        end else begin : g_keep
            assign inj_out = inj_flit_i;
        end
    endgenerate

    always_comb begin
        xplus_valid_o = 1'b0;
        xplus_flit_o  = '0;
        unique case (sel)
            SRC_XBAR: begin xplus_valid_o = xbar_valid_i; xplus_flit_o = xbar_flit_i; end
            SRC_RING: begin xplus_valid_o = ring_valid_i; xplus_flit_o = ring_flit_i; end
            SRC_INJ:  begin xplus_valid_o = inj_valid_i;  xplus_flit_o = inj_out;     end
            default:  begin xplus_valid_o = 1'b0;         xplus_flit_o = '0;          end
        endcase
    end

    assign xbar_ready_o = (sel == SRC_XBAR) && xplus_ready_i;
    assign inj_ready_o  = (sel == SRC_INJ) && xplus_ready_i;
    assign ring_ready_o = ((sel == SRC_RING) && xplus_ready_i) ||
                          (eject_valid_o && eject_ready_i);
    assign eject_flit_o = ring_flit_i;

endmodule

// File: rtl/dbp_bypass_chk.sv
module dbp_bypass_chk #(
    parameter int FLIT_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bypass,
    input logic              arb_idle,
    input logic              steer_idle,
    input logic              xbar_valid_i,
    input logic              xbar_ready_o,
    input logic              ring_valid_i,
    input logic              ring_ready_o,
    input logic              inj_valid_i,
    input logic              inj_ready_o,
    input logic [FLIT_W-1:0] inj_flit_i,
    input logic              xplus_valid_o,
    input logic              xplus_ready_i,
    input logic [FLIT_W-1:0] xplus_flit_o,
    input logic              eject_valid_o,
    input logic              eject_ready_i
);

    localparam int HEAD_BIT = FLIT_W - 1;
    localparam int TAIL_BIT = FLIT_W - 2;
    localparam int VC_BIT   = FLIT_W - 3;

    logic in_pkt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_pkt <= 1'b0;
        end else if (xplus_valid_o && xplus_ready_i) begin
            if (xplus_flit_o[TAIL_BIT])      in_pkt <= 1'b0;
            else if (xplus_flit_o[HEAD_BIT]) in_pkt <= 1'b1;
        end
    end

    // R1
    normal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass |-> (!ring_ready_o && !inj_ready_o && !eject_valid_o));

    // R2
    bypass_xbar_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && arb_idle) |-> !xbar_ready_o);

    // R5
    inj_vc_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid_i && inj_ready_o) |-> (xplus_valid_o && xplus_flit_o[VC_BIT] &&
        xplus_flit_o[HEAD_BIT:VC_BIT+1] == inj_flit_i[HEAD_BIT:VC_BIT+1] &&
        xplus_flit_o[VC_BIT-1:0] == inj_flit_i[VC_BIT-1:0]));

    // R6
    no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pkt && xplus_valid_o) |-> !xplus_flit_o[HEAD_BIT]);

    // R9
    mode_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bypass) |-> $past(arb_idle && steer_idle));

    // R11
    xplus_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xplus_valid_o |-> (xbar_valid_i || ring_valid_i || inj_valid_i));

    // R4
    eject_from_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eject_valid_o |-> (ring_valid_i && ring_ready_o == eject_ready_i));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (!bypass && arb_idle && steer_idle));

endmodule

bind dbp_bypass_top dbp_bypass_chk #(.FLIT_W(FLIT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bypass        (bypass_q),
    .arb_idle      (arb_idle),
    .steer_idle    (steer_idle),
    .xbar_valid_i  (xbar_valid_i),
    .xbar_ready_o  (xbar_ready_o),
    .ring_valid_i  (ring_valid_i),
    .ring_ready_o  (ring_ready_o),
    .inj_valid_i   (inj_valid_i),
    .inj_ready_o   (inj_ready_o),
    .inj_flit_i    (inj_flit_i),
    .xplus_valid_o (xplus_valid_o),
    .xplus_ready_i (xplus_ready_i),
    .xplus_flit_o  (xplus_flit_o),
    .eject_valid_o (eject_valid_o),
    .eject_ready_i (eject_ready_i)
);

// File: tb/tb_dbp_bypass_top.sv
module tb_dbp_bypass_top;

    localparam logic [3:0] ME = 4'd5;

    logic        clk;
    logic        rst_n;
    logic [3:0]  node_id;
    logic [2:0]  fault;
    logic        xbar_valid, xbar_ready;
    logic [63:0] xbar_flit;
    logic        ring_valid, ring_ready;
    logic [63:0] ring_flit;
    logic        inj_valid, inj_ready;
    logic [63:0] inj_flit;
    logic        xplus_valid, xplus_ready;
    logic [63:0] xplus_flit;
    logic        eject_valid, eject_ready;
    logic [63:0] eject_flit;

    dbp_bypass_top dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .node_id_i     (node_id),
        .fault_i       (fault),
        .xbar_valid_i  (xbar_valid),
        .xbar_flit_i   (xbar_flit),
        .xbar_ready_o  (xbar_ready),
        .ring_valid_i  (ring_valid),
        .ring_flit_i   (ring_flit),
        .ring_ready_o  (ring_ready),
        .inj_valid_i   (inj_valid),
        .inj_flit_i    (inj_flit),
        .inj_ready_o   (inj_ready),
        .xplus_valid_o (xplus_valid),
        .xplus_flit_o  (xplus_flit),
        .xplus_ready_i (xplus_ready),
        .eject_valid_o (eject_valid),
        .eject_flit_o  (eject_flit),
        .eject_ready_i (eject_ready)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    logic [63:0] xq[$];
    logic [63:0] rq[$];
    logic [63:0] iq[$];

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  m_owner;
    bit  m_ej;
    bit  m_mode;
    bit  first_cycle;
    logic [2:0] fault_v;

    function automatic logic [63:0] mk(bit h, bit t, bit vc, logic [3:0] d, int pay);
        return {h, t, vc, d, 57'(pay)};
    endfunction

    task automatic push_pkt(int s, int len, bit vc, logic [3:0] d, int tagv);
        for (int i = 0; i < len; i++) begin
            logic [63:0] f;
            f = mk(i == 0, i == len - 1, vc, d, tagv + i);
            case (s)
                0: xq.push_back(f);
                1: rq.push_back(f);
                default: iq.push_back(f);
            endcase
        end
    endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic step();
        logic [63:0] xf, rf, nf, exf;
        bit xv, rv, nv, rfwd, ej_on, exv, xr, er, contested, xfire, efire, ifire;
        int sel, n_owner;
        bit n_ej, n_mode;
        string tag;
        @(negedge clk);
        cyc++;
        xv = xq.size() > 0; xf = xv ? xq[0] : 64'h0;
        rv = rq.size() > 0; rf = rv ? rq[0] : 64'h0;
        nv = iq.size() > 0; nf = nv ? iq[0] : 64'h0;
        xr = (cyc % 5) != 3;
        er = (cyc % 4) != 1;
        xbar_valid = xv; xbar_flit = xf;
        ring_valid = rv; ring_flit = rf;
        inj_valid  = nv; inj_flit  = nf;
        xplus_ready = xr; eject_ready = er;
        fault = fault_v;
        #2;
        rfwd = m_mode && !m_ej && rv && rf[63] && rf[60:57] != ME;
        contested = 1'b0;
        if (m_owner != 0) sel = m_owner;
        else if (!m_mode) sel = (xv && xf[63]) ? 1 : 0;
        else if (rfwd) begin sel = 2; contested = nv && nf[63]; end
        else if (nv && nf[63]) sel = 3;
        else sel = 0;
        ej_on = m_mode && (m_ej ? rv : (rv && rf[63] && rf[60:57] == ME));
        case (sel)
            1: begin exv = xv; exf = xf; end
            2: begin exv = rv; exf = rf; end
            3: begin exv = nv; exf = nf; exf[61] = 1'b1; end
            default: begin exv = 1'b0; exf = 64'h0; end
        endcase
        xfire = exv && xr;
        efire = ej_on && er;
        ifire = (sel == 3) && xfire;

        if (first_cycle) tag = "R10";
        else if (m_owner != 0 && (|fault_v) != m_mode) tag = "R9";
        else if (m_owner != 0) tag = "R6";
        else tag = m_mode ? "R2" : "R1";
        check(tag, 64'(xplus_valid), 64'(exv));
        if (exv) begin
            if (contested) tag = "R7";
            else if (sel == 1) tag = "R1";
            else if (sel == 2) tag = "R3";
            else tag = "R5";
            check(tag, xplus_flit, exf);
        end
        check(m_mode ? "R2" : "R11", 64'(xbar_ready), 64'(sel == 1 && xr));
        check(m_mode ? "R11" : "R1", 64'(ring_ready), 64'((sel == 2 && xr) || efire));
        check(m_mode ? "R11" : "R1", 64'(inj_ready), 64'(ifire));
        check(ifire ? "R8" : "R4", 64'(eject_valid), 64'(ej_on));
        if (ej_on) check(ifire ? "R8" : "R4", eject_flit, rf);

        n_owner = m_owner;
        if (xfire) begin
            if (m_owner == 0 && !exf[62]) n_owner = sel;
            else if (m_owner != 0 && exf[62]) n_owner = 0;
        end
        n_ej = m_ej;
        if (efire) begin
            if (!m_ej && !rf[62]) n_ej = 1'b1;
            else if (m_ej && rf[62]) n_ej = 1'b0;
        end
        n_mode = m_mode;
        if (m_owner == 0 && !m_ej) n_mode = |fault_v;

        @(posedge clk);
        m_owner = n_owner; m_ej = n_ej; m_mode = n_mode;
        first_cycle = 1'b0;
        if (xfire && sel == 1) void'(xq.pop_front());
        if ((xfire && sel == 2) || efire) void'(rq.pop_front());
        if (ifire) void'(iq.pop_front());
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; node_id = ME; fault_v = 3'b001; fault = 3'b001;
        xbar_valid = 0; ring_valid = 0; inj_valid = 0;
        xbar_flit = '0; ring_flit = '0; inj_flit = '0;
        xplus_ready = 1'b1; eject_ready = 1'b1;
        m_owner = 0; m_ej = 0; m_mode = 0; first_cycle = 1'b1;
        repeat (3) @(posedge clk);
        #3;
        // R10: outputs idle while reset is held
        check("R10", 64'(xplus_valid), 64'h0);
        check("R10", 64'(eject_valid), 64'h0);
        #2 rst_n = 1'b1;

        // R10: normal mode in first cycle even with a fault flagged
        push_pkt(0, 1, 1'b0, 4'd2, 'h100);
        step();
        fault_v = 3'b000;
        run(3);

        // R1: crossbar traffic in normal mode; ring/inj must wait
        push_pkt(0, 4, 1'b0, 4'd3, 'h200);
        push_pkt(0, 2, 1'b1, 4'd6, 'h210);
        push_pkt(1, 3, 1'b0, 4'd3, 'h300);
        push_pkt(2, 2, 1'b0, 4'd9, 'h400);
        run(15);

        // R9: fault arrives mid crossbar packet; R7 contention afterwards
        push_pkt(0, 8, 1'b0, 4'd1, 'h500);
        run(3);
        fault_v = 3'b010;
        run(20);

        // R3 R4 R5 R8: mixed ring forward, ejection, injection
        push_pkt(1, 3, 1'b0, ME,   'h600);
        push_pkt(1, 2, 1'b1, 4'd7, 'h610);
        push_pkt(2, 4, 1'b0, 4'd2, 'h700);
        push_pkt(2, 2, 1'b0, 4'd9, 'h710);
        run(25);

        // R8: long ejection alongside long injection, then a one-flit eject
        push_pkt(1, 5, 1'b0, ME,   'h800);
        push_pkt(2, 5, 1'b0, 4'd4, 'h900);
        push_pkt(1, 1, 1'b1, ME,   'h810);
        run(20);

        // R1: back to normal once faults clear
        fault_v = 3'b000;
        push_pkt(0, 3, 1'b0, 4'd8, 'hA00);
        run(12);

        // R11: every stream fully drained
        check("R11", 64'(xq.size()), 64'h0);
        check("R11", 64'(rq.size()), 64'h0);
        check("R11", 64'(iq.size()), 64'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule